// File: doc/BRIEF.md
# Cascaded Quadrature Position Counter with Linked Capture

This block builds a 32-bit position count from two 16-bit stages. The lower stage decodes a two-phase incremental encoder. It counts every edge of both phases. The upper stage holds the high half of the position. It moves one step for each wrap of the lower stage: up on a wrap past the top of the range, down on a wrap past zero. Software enables each stage separately through a small register port. The upper stage follows the lower stage only when its count-source field selects the lower stage's wrap events.

Each stage has two capture registers, named A and B. Each capture register takes a snapshot of its own stage's counter on a rising edge of its own capture pin. Four cross-link enables let the pin of the other stage fire the capture too. With these enabled, one external edge freezes both 16-bit halves of the position in the same clock. The two halves then stay coherent even when a carry or borrow is being applied in that cycle.

Top module: `cascade_qcounter`

## Requirements
- R1: After reset, every readable register reads 0: both counters, all four capture registers, the count-source field, the run bits and the cross-link enables.
- R2: The phase inputs are decoded at four counts per encoder cycle. With phases written as {A,B}, the steps 00→10→11→01→00 each add one to the lower counter. The reverse steps each subtract one. A change of both phases at once is ignored.
- R3: The lower counter moves only while run bit 0 (address 1) is 1. The upper counter moves only while run bit 1 is 1. While its bit is 0, a stage holds its value.
- R4: The count-source field is bits 3:0 at address 0. When it is 4'hF and the upper stage runs, the upper counter adds one on each lower overflow and subtracts one on each lower underflow. Any other code leaves the upper counter idle.
- R5: An overflow is the lower counter stepping up from 16'hFFFF to 16'h0000. An underflow is the lower counter stepping down from 16'h0000 to 16'hFFFF. Each lasts one cycle, and the two never coincide.
- R6: A rising edge on a capture pin loads the counter of that pin's stage into the capture register of the same letter. The capture pins are loA, loB, hiA and hiB. The capture registers are read at addresses 5 (lower A), 6 (lower B), 7 (upper A) and 8 (upper B). Writes to these addresses are ignored.
- R7: The cross-link enables are at address 2. Bit 0 lets loA also load upper A. Bit 1 lets loB also load upper B. Bit 2 lets hiA also load lower A. Bit 3 lets hiB also load lower B. While a bit is 0, the other pin has no effect on that register.
- R8: When the own pin and the linked pin both rise in the same cycle, the capture register is loaded once, with the current counter value.
- R9: A capture in the same cycle as a lower-stage wrap stores, in both halves, the values from before that step.
- R10: A write to a counter (address 3 lower, address 4 upper) wins over a count step in the same cycle. A lower counter that is written in that cycle produces no wrap event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseA | input | 1 | Encoder phase A, asynchronous |
| phaseB | input | 1 | Encoder phase B, asynchronous |
| capPinLoA | input | 1 | Capture pin A of the lower stage |
| capPinLoB | input | 1 | Capture pin B of the lower stage |
| capPinHiA | input | 1 | Capture pin A of the upper stage |
| capPinHiB | input | 1 | Capture pin B of the upper stage |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Write strobe, one cycle |
| regWrData | input | CNT_W | Write data |
| regRdData | output | CNT_W | Read data for regAddr, combinational |

## Verification
On every cycle the assertions check several properties:
- the carry and borrow into the upper counter;
- that the upper half stays still when no wrap is routed to it;
- the values the lower counter takes after a wrap, and that overflow and underflow exclude each other;
- that a capture register holds unless it is strobed, and that a strobed capture stores the counter value from before the step;
- that a counter write wins over a count step.

The bench scenarios are the only place where the following can be seen:
- the decoding of real phase sequences through the synchronizers;
- the pin-to-register routing under each setting of the cross-link enables;
- a single edge snapshotting both halves during a carry;
- the run bits and non-selecting source codes leaving the count untouched.

// File: rtl/cqc_pkg.sv
package cqc_pkg;

  typedef enum logic [3:0] {
    ADR_SRC    = 4'd0,
    ADR_RUN    = 4'd1,
    ADR_XLINK  = 4'd2,
    ADR_CNT_LO = 4'd3,
    ADR_CNT_HI = 4'd4,
    ADR_CAP_LA = 4'd5,
    ADR_CAP_LB = 4'd6,
    ADR_CAP_HA = 4'd7,
    ADR_CAP_HB = 4'd8
  } cqc_addr_e;

  localparam logic [3:0] SRC_LOWER_WRAP = 4'hF;

  // Strobes from control to datapath, all valid for one cycle.
  typedef struct packed {
    logic loStep;   // lower counter steps this cycle
    logic loUp;     // direction of that step
    logic hiEn;     // upper stage is running and follows lower wraps
    logic capLoA;
    logic capLoB;
    logic capHiA;
    logic capHiB;
    logic wrLo;     // register write to the lower counter
    logic wrHi;     // register write to the upper counter
  } cqc_strobe_t;

endpackage

// File: rtl/cqc_sync.sv
module cqc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[g] <= '0;
      else if (g == 0) stageQ[g] <= din;
      else stageQ[g] <= stageQ[(g == 0) ? 0 : g-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/cqc_ctrl.sv
module cqc_ctrl
  import cqc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseA,
  input  logic             phaseB,
  input  logic [3:0]       capPins,   // {hiB, hiA, loB, loA}
  input  logic [3:0]       regAddr,
  input  logic             regWrEn,
  input  logic [CNT_W-1:0] regWrData,
  output cqc_strobe_t      strobe,
  output logic             cfgHit,
  output logic [CNT_W-1:0] cfgRdData
);

  localparam int IN_W = 6;

  logic [IN_W-1:0] syncIn, syncOut, prevQ;
  logic [1:0]      phNow, phOld;
  logic [3:0]      capRise;
  logic            stepUp, stepDn;

  logic [3:0] srcSel;
  logic [1:0] runBits;
  logic [3:0] xLink;

  assign syncIn = {phaseA, phaseB, capPins};

  cqc_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (syncIn),
    .dout(syncOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncOut;
  end

  assign phNow   = syncOut[5:4];
  assign phOld   = prevQ[5:4];
  assign capRise = syncOut[3:0] & ~prevQ[3:0];

  // 4x decoding: {A,B} going 00->10->11->01->00 counts up
  always_comb begin
    stepUp = 1'b0;
    stepDn = 1'b0;
    unique case ({phOld, phNow})
      4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: stepUp = 1'b1;
      4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: stepDn = 1'b1;
      default: ;
    endcase
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel  <= '0;
      runBits <= '0;
      xLink   <= '0;
    end else if (regWrEn) begin
      unique case (regAddr)
        ADR_SRC:   srcSel  <= regWrData[3:0];
        ADR_RUN:   runBits <= regWrData[1:0];
        ADR_XLINK: xLink   <= regWrData[3:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.wrLo   = regWrEn && (regAddr == ADR_CNT_LO);
    strobe.wrHi   = regWrEn && (regAddr == ADR_CNT_HI);
    strobe.loStep = runBits[0] && (stepUp || stepDn) && !strobe.wrLo;
    strobe.loUp   = stepUp;
    strobe.hiEn   = runBits[1] && (srcSel == SRC_LOWER_WRAP);
    strobe.capLoA = capRise[0] || (xLink[2] && capRise[2]);
    strobe.capLoB = capRise[1] || (xLink[3] && capRise[3]);
    strobe.capHiA = capRise[2] || (xLink[0] && capRise[0]);
    strobe.capHiB = capRise[3] || (xLink[1] && capRise[1]);
  end

  always_comb begin
    cfgHit    = 1'b1;
    cfgRdData = '0;
    unique case (regAddr)
      ADR_SRC:   cfgRdData[3:0] = srcSel;
      ADR_RUN:   cfgRdData[1:0] = runBits;
      ADR_XLINK: cfgRdData[3:0] = xLink;
      default:   cfgHit = 1'b0;
    endcase
  end

endmodule

// File: rtl/cqc_datapath.sv
module cqc_datapath
  import cqc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cqc_strobe_t                strobe,
  input  logic [CNT_W-1:0]           regWrData,
  input  logic [3:0]                 regAddr,
  output logic [CNT_W-1:0]           cntLo,
  output logic [CNT_W-1:0]           cntHi,
  output logic                       ovf,
  output logic                       unf,
  output logic [3:0][CNT_W-1:0]      capRegs,   // {HB, HA, LB, LA}
  output logic [CNT_W-1:0]           dpRdData
);

  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] TOP  = '1;
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic       hiStep;
  logic [3:0] capStb;

  assign ovf    = strobe.loStep &&  strobe.loUp && (cntLo == TOP);
  assign unf    = strobe.loStep && !strobe.loUp && (cntLo == ZERO);
  assign hiStep = strobe.hiEn && (ovf || unf) && !strobe.wrHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntLo <= '0;
    else if (strobe.wrLo)   cntLo <= regWrData;
    else if (strobe.loStep) cntLo <= strobe.loUp ? cntLo + ONE : cntLo - ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntHi <= '0;
    else if (strobe.wrHi) cntHi <= regWrData;
    else if (hiStep)      cntHi <= ovf ? cntHi + ONE : cntHi - ONE;
  end

  assign capStb = {strobe.capHiB, strobe.capHiA, strobe.capLoB, strobe.capLoA};

  // Captures take the pre-step counter values by register semantics.
  for (genvar c = 0; c < 4; c++) begin : g_cap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          capRegs[c] <= '0;
      else if (capStb[c]) capRegs[c] <= (c < 2) ? cntLo : cntHi;
    end
  end

  always_comb begin
    unique case (regAddr)
      ADR_CNT_LO: dpRdData = cntLo;
      ADR_CNT_HI: dpRdData = cntHi;
      ADR_CAP_LA: dpRdData = capRegs[0];
      ADR_CAP_LB: dpRdData = capRegs[1];
      ADR_CAP_HA: dpRdData = capRegs[2];
      ADR_CAP_HB: dpRdData = capRegs[3];
      default:    dpRdData = '0;
    endcase
  end

endmodule

// File: rtl/cascade_qcounter.sv
module cascade_qcounter
  import cqc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseA,
  input  logic             phaseB,
  input  logic             capPinLoA,
  input  logic             capPinLoB,
  input  logic             capPinHiA,
  input  logic             capPinHiB,
  input  logic [3:0]       regAddr,
  input  logic             regWrEn,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData
);

  cqc_strobe_t              strobe;
  logic                     cfgHit, ovf, unf;
  logic [CNT_W-1:0]         cfgRdData, dpRdData, cntLo, cntHi;
  logic [3:0][CNT_W-1:0]    capRegs;

  cqc_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .phaseA   (phaseA),
    .phaseB   (phaseB),
    .capPins  ({capPinHiB, capPinHiA, capPinLoB, capPinLoA}),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .strobe   (strobe),
    .cfgHit   (cfgHit),
    .cfgRdData(cfgRdData)
  );

  cqc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regWrData(regWrData),
    .regAddr  (regAddr),
    .cntLo    (cntLo),
    .cntHi    (cntHi),
    .ovf      (ovf),
    .unf      (unf),
    .capRegs  (capRegs),
    .dpRdData (dpRdData)
  );

  assign regRdData = cfgHit ? cfgRdData : dpRdData;

endmodule

// File: rtl/cqc_checker.sv
module cqc_checker
  import cqc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input cqc_strobe_t           strobe,
  input logic                  ovf,
  input logic                  unf,
  input logic [CNT_W-1:0]      cntLo,
  input logic [CNT_W-1:0]      cntHi,
  input logic [CNT_W-1:0]      regWrData,
  input logic [3:0][CNT_W-1:0] capRegs
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_carry_up_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && strobe.hiEn && !strobe.wrHi) |=> cntHi == $past(cntHi) + ONE);

  assert_borrow_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    (unf && strobe.hiEn && !strobe.wrHi) |=> cntHi == $past(cntHi) - ONE);

  assert_hi_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!(strobe.hiEn && (ovf || unf)) && !strobe.wrHi) |=> $stable(cntHi));

  assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> cntLo == '0);

  assert_wrap_down_R5: assert property (@(posedge clk) disable iff (!rstN)
    unf |=> cntLo == '1);

  assert_wrap_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(ovf && unf));

  assert_cap_pre_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capHiA |=> capRegs[2] == $past(cntHi));

  assert_cap_lo_pre_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capLoA |=> capRegs[0] == $past(cntLo));

  assert_cap_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capLoB |=> $stable(capRegs[1]));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrLo |=> cntLo == $past(regWrData));

endmodule

bind cascade_qcounter cqc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .strobe   (strobe),
  .ovf      (ovf),
  .unf      (unf),
  .cntLo    (cntLo),
  .cntHi    (cntHi),
  .regWrData(regWrData),
  .capRegs  (capRegs)
);

// File: tb/tb_cascade_qcounter.sv
`timescale 1ns/1ps
module tb_cascade_qcounter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phaseA = 1'b0, phaseB = 1'b0;
  logic        capPinLoA = 1'b0, capPinLoB = 1'b0, capPinHiA = 1'b0, capPinHiB = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;

  int compared = 0, mismatched = 0;
  bit done = 0;
  int phIdx = 0;               // position in 00,10,11,01
  logic [31:0] pos;            // model {hi, lo}
  logic [15:0] expCap [4];
  logic [3:0]  xl;

  always #2 clk = ~clk;        // 250 MHz

  cascade_qcounter dut (.*);

  function automatic logic [1:0] phaseOf(int idx);
    case (idx & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  // Expected capture strobes from pin p and link enables (R6, R7)
  function automatic logic [3:0] capMask(int p, logic [3:0] x);
    logic [3:0] m;
    m = 4'b0;
    m[p] = 1'b1;
    if (p == 0 && x[0]) m[2] = 1'b1;
    if (p == 1 && x[1]) m[3] = 1'b1;
    if (p == 2 && x[2]) m[0] = 1'b1;
    if (p == 3 && x[3]) m[1] = 1'b1;
    return m;
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic rdCheck(string tag, logic [3:0] a, logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic drivePhase(bit up);
    phIdx = up ? phIdx + 1 : phIdx + 3;
    {phaseA, phaseB} = phaseOf(phIdx);
  endtask

  task automatic step(bit up);
    @(negedge clk);
    drivePhase(up);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulsePins(logic [3:0] pins);   // {hiB,hiA,loB,loA}
    @(negedge clk);
    {capPinHiB, capPinHiA, capPinLoB, capPinLoA} = pins;
    repeat (4) @(negedge clk);
    {capPinHiB, capPinHiA, capPinLoB, capPinLoA} = 4'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkCaps(string tag);
    rdCheck({tag, " capLA"}, 4'd5, expCap[0]);
    rdCheck({tag, " capLB"}, 4'd6, expCap[1]);
    rdCheck({tag, " capHA"}, 4'd7, expCap[2]);
    rdCheck({tag, " capHB"}, 4'd8, expCap[3]);
  endtask

  task automatic checkPos(string tag);
    rdCheck({tag, " lo"}, 4'd3, pos[15:0]);
    rdCheck({tag, " hi"}, 4'd4, pos[31:16]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) expCap[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of all registers
    for (int a = 0; a <= 8; a++) rdCheck("R1 reset", a[3:0], 16'h0);

    // R2: 4x decoding both directions; R3: upper stage not running
    wr(4'd1, 16'h1);
    for (int i = 0; i < 4; i++) step(1);
    rdCheck("R2 up four", 4'd3, 16'h0004);
    for (int i = 0; i < 6; i++) step(0);
    rdCheck("R2 down six", 4'd3, 16'hFFFE);
    rdCheck("R3 hi stopped", 4'd4, 16'h0000);
    // R2: both phases changing at once is ignored
    @(negedge clk); {phaseA, phaseB} = ~{phaseA, phaseB}; phIdx += 2;
    repeat (4) @(negedge clk);
    rdCheck("R2 double change", 4'd3, 16'hFFFE);

    // R3: lower stopped
    wr(4'd1, 16'h0);
    for (int i = 0; i < 3; i++) step(1);
    rdCheck("R3 lo stopped", 4'd3, 16'hFFFE);

    // R4: non-selecting source code leaves upper idle
    wr(4'd1, 16'h3);
    wr(4'd0, 16'h3);
    for (int i = 0; i < 3; i++) step(1);
    rdCheck("R4 idle lo", 4'd3, 16'h0001);
    rdCheck("R4 idle hi", 4'd4, 16'h0000);

    // R4/R5: carry and borrow
    wr(4'd0, 16'hF);
    rdCheck("R4 src readback", 4'd0, 16'h000F);
    wr(4'd3, 16'hFFFF);
    step(1);
    rdCheck("R5 ovf lo", 4'd3, 16'h0000);
    rdCheck("R4 carry hi", 4'd4, 16'h0001);
    step(0);
    rdCheck("R5 unf lo", 4'd3, 16'hFFFF);
    rdCheck("R4 borrow hi", 4'd4, 16'h0000);
    step(0);
    rdCheck("R5 no wrap hi", 4'd4, 16'h0000);

    // R10: write wins over a step in the same cycle, no wrap produced
    wr(4'd3, 16'hFFFF);
    @(negedge clk); drivePhase(1);
    @(negedge clk);
    @(negedge clk); regAddr = 4'd3; regWrData = 16'h1234; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
    repeat (3) @(negedge clk);
    rdCheck("R10 write wins lo", 4'd3, 16'h1234);
    rdCheck("R10 no carry hi", 4'd4, 16'h0000);

    // R6/R7: own-pin captures with links off
    wr(4'd3, 16'h0100);
    wr(4'd4, 16'h0007);
    pulsePins(4'b0001);
    expCap[0] = 16'h0100;
    checkCaps("R6 R7 loA own");
    pulsePins(4'b1000);
    expCap[3] = 16'h0007;
    checkCaps("R6 R7 hiB own");
    // R6: writes to capture registers ignored
    wr(4'd5, 16'hBEEF);
    rdCheck("R6 cap write ignored", 4'd5, 16'h0100);

    // R7: links on, one edge snapshots both halves
    wr(4'd2, 16'hF);
    rdCheck("R7 link readback", 4'd2, 16'h000F);
    wr(4'd3, 16'h0222);
    pulsePins(4'b0001);
    expCap[0] = 16'h0222; expCap[2] = 16'h0007;
    checkCaps("R7 loA linked");
    // R8: own and linked pin together -> one capture of current value
    wr(4'd4, 16'h0033);
    pulsePins(4'b1010);
    expCap[1] = 16'h0222; expCap[3] = 16'h0033;
    checkCaps("R8 simultaneous");

    // R9: capture in the wrap cycle stores pre-step halves
    wr(4'd3, 16'hFFFF);
    wr(4'd4, 16'h0005);
    @(negedge clk); drivePhase(1); capPinHiA = 1'b1;
    repeat (4) @(negedge clk);
    capPinHiA = 1'b0;
    repeat (4) @(negedge clk);
    expCap[0] = 16'hFFFF; expCap[2] = 16'h0005;
    checkCaps("R9 wrap cycle");
    rdCheck("R9 lo after", 4'd3, 16'h0000);
    rdCheck("R9 hi after", 4'd4, 16'h0006);

    // Random: steps, near-wrap writes, captures with random links (R2 R4 R5 R7)
    pos = 32'h0006_0000;
    for (int it = 0; it < 250; it++) begin
      int kind;
      kind = $urandom_range(0, 9);
      if (kind == 0) begin
        logic [15:0] v;
        v = ($urandom_range(0, 1) != 0) ? 16'hFFFE : 16'h0001;
        wr(4'd3, v);
        pos[15:0] = v;
      end else if (kind == 1) begin
        int p;
        logic [3:0] m;
        xl = 4'($urandom_range(0, 15));
        wr(4'd2, {12'h0, xl});
        p = $urandom_range(0, 3);
        m = capMask(p, xl);
        pulsePins(4'b0001 << p);
        for (int c = 0; c < 4; c++)
          if (m[c]) expCap[c] = (c < 2) ? pos[15:0] : pos[31:16];
        checkCaps("R7 random");
      end else begin
        bit up;
        int n;
        up = ($urandom_range(0, 1) != 0);
        n = $urandom_range(1, 4);
        for (int k = 0; k < n; k++) begin
          step(up);
          pos = up ? pos + 32'd1 : pos - 32'd1;
        end
        checkPos("R2 R4 R5 random");
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule